// File: doc/BRIEF.md
# Banked Stack Pointer and Thread Control Unit

This block keeps the two stack pointers of a processor core, a main pointer and a process pointer, together with a three-bit thread control word. Register 13 maps onto whichever pointer is active. Which pointer is active depends on the processor mode and on the stack-select bit of the control word. The control word also holds the thread privilege bit and a floating-point-context-active flag. The block produces the effective privilege level of the code that is running.

The core drives the current mode (thread or handler) and the register-13 write port, and reads back the active pointer. Privileged software writes the control word through its own port. The exception logic pulses a strobe on entry and a strobe on return. The return strobe comes with a two-bit code that names the target mode and the target stack. While reset is asserted, the main pointer is loaded from the reset-vector word.

Top module: `banked_sp_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, the main pointer loads `rst_vec_word` unchanged and the control word clears. After reset, `sp_rd` equals `rst_vec_word`, `ctrl_rd` is 0 and `priv` is 1.
- R2: In thread mode (`handler_mode`=0), `sp_rd` shows the main pointer when the stack-select bit (control bit 1) is 0, and the process pointer when it is 1.
- R3: In handler mode, `sp_rd` shows the main pointer whatever the stack-select bit holds, and register-13 writes go to the main pointer.
- R4: In handler mode, `ctrl_rd[1]` reads 0. A control write in handler mode leaves the stored stack-select bit unchanged, and the stored value shows again once thread mode returns.
- R5: A register-13 write updates only the active pointer, with bits [1:0] forced to 0. The new value shows on `sp_rd` one cycle later, and the other pointer keeps its value.
- R6: A control write made while `priv` is 0 is dropped, and the control word keeps its previous value.
- R7: An accepted control write loads bit 0 (1 = unprivileged thread) and bit 2 (floating-point context active). `ctrl_rd[31:3]` always reads 0. `priv` is 1 in handler mode, and in thread mode it is the inverse of bit 0.
- R8: `ret_code[1]`=1 means the return goes to thread mode, and `ret_code[0]`=1 means it uses the process stack. An exception return whose code targets thread mode loads the stack-select bit from `ret_code[0]`, taking priority over a control write in the same cycle. A return that targets handler mode leaves the bit unchanged.
- R9: An exception-entry strobe clears the floating-point-context bit, taking priority over a control write in the same cycle.
- R10: With `FP_PRESENT`=0, control bit 2 always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rst_vec_word | input | XLEN | Initial main pointer value loaded during reset |
| handler_mode | input | 1 | Current mode: 1 = handler, 0 = thread |
| sp_wr_en | input | 1 | Register-13 write strobe |
| sp_wr_data | input | XLEN | Register-13 write data |
| sp_rd | output | XLEN | Active stack pointer (register 13 read) |
| ctrl_wr_en | input | 1 | Control write strobe |
| ctrl_wr_data | input | 3 | Control write data: bit 0 unprivileged, bit 1 stack select, bit 2 FP context |
| ctrl_rd | output | XLEN | Control word readback |
| priv | output | 1 | Effective privilege of running code: 1 = privileged |
| exc_entry | input | 1 | Exception entry strobe |
| exc_ret | input | 1 | Exception return strobe |
| ret_code | input | 2 | Return target: bit 1 thread mode, bit 0 process stack |

## Verification
Mode-dependent results (`sp_rd`, `ctrl_rd[1]` and `priv`) follow `handler_mode` combinationally in the same cycle. The bench changes the mode, waits 1 ns and then samples. Register-13 writes, control writes, entry and return strobes take effect at the next rising edge, so their results are due one cycle after the strobe. The bench drives every strobe 1 ns after an edge and samples 1 ns after the following edge. Cases that check something is ignored are read back at the ports: the stack-select bit is read after leaving handler mode, and the other pointer is read after toggling the select bit.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam int CTRL_W       = 3;
  localparam int CB_UNPRIV    = 0;
  localparam int CB_STACKSEL  = 1;
  localparam int CB_FPCTX     = 2;
  localparam int RC_PROC      = 0;
  localparam int RC_THREAD    = 1;

  typedef struct packed {
    logic fpctx;
    logic stacksel;
    logic unpriv;
  } ctrl_t;

  function automatic logic f_use_proc(input logic handler, input logic stacksel);
    return ~handler & stacksel;
  endfunction

  function automatic logic f_priv(input logic handler, input logic unpriv);
    return handler | ~unpriv;
  endfunction

endpackage

// File: rtl/bsp_ctrl_reg.sv
module bsp_ctrl_reg
  import bsp_pkg::*;
#(
  parameter bit FP_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              handler_mode,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              exc_entry,
  input  logic              exc_ret,
  input  logic [1:0]        ret_code,
  output ctrl_t             ctrl_q,
  output logic              wr_accept,
  output logic              wr_drop,
  output logic              ret_to_thread
);

  ctrl_t ctrl_d;
  logic  may_write;

  assign may_write     = f_priv(handler_mode, ctrl_q.unpriv);
  assign wr_accept     = wr_en & may_write;
  assign wr_drop       = wr_en & ~may_write;
  assign ret_to_thread = exc_ret & ret_code[RC_THREAD];

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_accept) begin
      ctrl_d.unpriv = wr_data[CB_UNPRIV];
      if (!handler_mode) ctrl_d.stacksel = wr_data[CB_STACKSEL];
      ctrl_d.fpctx = wr_data[CB_FPCTX];
    end
    if (ret_to_thread) ctrl_d.stacksel = ret_code[RC_PROC];
    if (exc_entry)     ctrl_d.fpctx    = 1'b0;
    if (!FP_PRESENT)   ctrl_d.fpctx    = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

endmodule

// File: rtl/bsp_sp_bank.sv
module bsp_sp_bank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] rst_vec_word,
  input  logic            wr_en,
  input  logic [XLEN-1:0] wr_data,
  input  logic            use_proc,
  output logic [XLEN-1:0] main_q,
  output logic [XLEN-1:0] proc_q,
  output logic            wr_main,
  output logic            wr_proc
);

  localparam int ALIGN_BITS = 2;

  function automatic logic [XLEN-1:0] f_align(input logic [XLEN-1:0] d);
    return {d[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction

  assign wr_main = wr_en & ~use_proc;
  assign wr_proc = wr_en & use_proc;

  always_ff @(posedge clk) begin
    if (!rst_n)       main_q <= rst_vec_word;
    else if (wr_main) main_q <= f_align(wr_data);
  end

  // Process pointer has no defined reset value.
  always_ff @(posedge clk) begin
    if (rst_n && wr_proc) proc_q <= f_align(wr_data);
  end

endmodule

// File: rtl/bsp_view.sv
module bsp_view
  import bsp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit FP_PRESENT = 1'b1
) (
  input  logic            handler_mode,
  input  ctrl_t           ctrl_q,
  input  logic [XLEN-1:0] main_q,
  input  logic [XLEN-1:0] proc_q,
  output logic            use_proc,
  output logic [XLEN-1:0] sp_rd,
  output logic [XLEN-1:0] ctrl_rd,
  output logic            priv
);

  localparam int PAD_W = XLEN - CTRL_W;

  logic fp_view;
  logic sel_view;

  assign use_proc = f_use_proc(handler_mode, ctrl_q.stacksel);
  assign sp_rd    = use_proc ? proc_q : main_q;
  assign priv     = f_priv(handler_mode, ctrl_q.unpriv);
  assign sel_view = ctrl_q.stacksel & ~handler_mode;

  generate
    if (FP_PRESENT) begin : g_fp
      assign fp_view = ctrl_q.fpctx;
    end else begin : g_nofp
      assign fp_view = 1'b0;
    end
  endgenerate

  assign ctrl_rd = {{PAD_W{1'b0}}, fp_view, sel_view, ctrl_q.unpriv};

endmodule

// File: rtl/banked_sp_unit.sv
module banked_sp_unit
  import bsp_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit FP_PRESENT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   rst_vec_word,
  input  logic              handler_mode,
  input  logic              sp_wr_en,
  input  logic [XLEN-1:0]   sp_wr_data,
  output logic [XLEN-1:0]   sp_rd,
  input  logic              ctrl_wr_en,
  input  logic [CTRL_W-1:0] ctrl_wr_data,
  output logic [XLEN-1:0]   ctrl_rd,
  output logic              priv,
  input  logic              exc_entry,
  input  logic              exc_ret,
  input  logic [1:0]        ret_code
);

  ctrl_t           ctrl_q;
  logic            ctrl_wr_accept;
  logic            ctrl_wr_drop;
  logic            ret_to_thread;
  logic            use_proc;
  logic [XLEN-1:0] main_q;
  logic [XLEN-1:0] proc_q;
  logic            sp_wr_main;
  logic            sp_wr_proc;

  bsp_ctrl_reg #(.FP_PRESENT(FP_PRESENT)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .handler_mode (handler_mode),
    .wr_en        (ctrl_wr_en),
    .wr_data      (ctrl_wr_data),
    .exc_entry    (exc_entry),
    .exc_ret      (exc_ret),
    .ret_code     (ret_code),
    .ctrl_q       (ctrl_q),
    .wr_accept    (ctrl_wr_accept),
    .wr_drop      (ctrl_wr_drop),
    .ret_to_thread(ret_to_thread)
  );

  bsp_sp_bank #(.XLEN(XLEN)) u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_vec_word(rst_vec_word),
    .wr_en       (sp_wr_en),
    .wr_data     (sp_wr_data),
    .use_proc    (use_proc),
    .main_q      (main_q),
    .proc_q      (proc_q),
    .wr_main     (sp_wr_main),
    .wr_proc     (sp_wr_proc)
  );

  bsp_view #(.XLEN(XLEN), .FP_PRESENT(FP_PRESENT)) u_view (
    .handler_mode(handler_mode),
    .ctrl_q      (ctrl_q),
    .main_q      (main_q),
    .proc_q      (proc_q),
    .use_proc    (use_proc),
    .sp_rd       (sp_rd),
    .ctrl_rd     (ctrl_rd),
    .priv        (priv)
  );

endmodule

// File: rtl/bsp_checker.sv
module bsp_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            handler_mode,
  input logic            exc_entry,
  input logic            exc_ret,
  input logic [1:0]      ret_code,
  input logic [XLEN-1:0] sp_rd,
  input logic [XLEN-1:0] ctrl_rd,
  input logic            priv,
  input logic [XLEN-1:0] main_q,
  input logic [XLEN-1:0] proc_q,
  input logic [2:0]      ctrl_q,
  input logic            ctrl_wr_drop,
  input logic            ret_to_thread,
  input logic            sp_wr_main,
  input logic            sp_wr_proc
);

  AST_HANDLER_USES_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> sp_rd == main_q); // R3

  AST_HANDLER_SEL_RAZ: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> !ctrl_rd[1]); // R4

  AST_HANDLER_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    handler_mode |-> priv); // R7

  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rd[XLEN-1:3] == '0); // R7

  AST_MAIN_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_main |=> main_q[1:0] == 2'b00); // R5

  AST_PROC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    sp_wr_proc |=> proc_q[1:0] == 2'b00); // R5

  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_drop && !exc_ret && !exc_entry) |=> $stable(ctrl_q)); // R6

  AST_RET_SETS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_ret && ret_code[1]) |=> ctrl_q[1] == $past(ret_code[0])); // R8

  AST_RET_THREAD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ret_to_thread |-> exc_ret); // R8

  AST_ENTRY_CLEARS_FP: assert property (@(posedge clk) disable iff (!rst_n)
    exc_entry |=> !ctrl_q[2]); // R9

endmodule

bind banked_sp_unit bsp_checker #(.XLEN(XLEN)) u_bsp_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .handler_mode (handler_mode),
  .exc_entry    (exc_entry),
  .exc_ret      (exc_ret),
  .ret_code     (ret_code),
  .sp_rd        (sp_rd),
  .ctrl_rd      (ctrl_rd),
  .priv         (priv),
  .main_q       (main_q),
  .proc_q       (proc_q),
  .ctrl_q       (ctrl_q),
  .ctrl_wr_drop (ctrl_wr_drop),
  .ret_to_thread(ret_to_thread),
  .sp_wr_main   (sp_wr_main),
  .sp_wr_proc   (sp_wr_proc)
);

// File: tb/test_banked_sp_unit.sv
module test_banked_sp_unit;

  localparam int XLEN = 32;
  localparam logic [31:0] VEC = 32'h2000_1000;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [XLEN-1:0] rst_vec_word = VEC;
  logic            handler_mode = 1'b0;
  logic            sp_wr_en = 1'b0;
  logic [XLEN-1:0] sp_wr_data = '0;
  logic            ctrl_wr_en = 1'b0;
  logic [2:0]      ctrl_wr_data = '0;
  logic            exc_entry = 1'b0;
  logic            exc_ret = 1'b0;
  logic [1:0]      ret_code = '0;
  logic [XLEN-1:0] sp_rd, ctrl_rd, sp_rd_nf, ctrl_rd_nf;
  logic            priv, priv_nf;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  banked_sp_unit #(.XLEN(XLEN), .FP_PRESENT(1'b1)) i_banked_sp_unit (
    .clk(clk), .rst_n(rst_n), .rst_vec_word(rst_vec_word), .handler_mode(handler_mode),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd(sp_rd),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd(ctrl_rd), .priv(priv),
    .exc_entry(exc_entry), .exc_ret(exc_ret), .ret_code(ret_code));

  banked_sp_unit #(.XLEN(XLEN), .FP_PRESENT(1'b0)) i_nofp (
    .clk(clk), .rst_n(rst_n), .rst_vec_word(rst_vec_word), .handler_mode(handler_mode),
    .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .sp_rd(sp_rd_nf),
    .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_data(ctrl_wr_data), .ctrl_rd(ctrl_rd_nf), .priv(priv_nf),
    .exc_entry(exc_entry), .exc_ret(exc_ret), .ret_code(ret_code));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_sp(input logic [31:0] d);
    sp_wr_en = 1'b1; sp_wr_data = d;
    step();
    sp_wr_en = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [2:0] d);
    ctrl_wr_en = 1'b1; ctrl_wr_data = d;
    step();
    ctrl_wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic h);
    handler_mode = h;
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    rst_n = 1'b1;
    chk("R1 sp after reset", sp_rd, VEC);
    chk("R1 ctrl after reset", ctrl_rd, 32'h0);
    chk("R1 priv after reset", {31'b0, priv}, 32'h1);
  endtask

  task automatic t_thread_select();
    wr_sp(32'h2000_0FF7);
    chk("R5 main aligned write", sp_rd, 32'h2000_0FF4);
    wr_ctrl(3'b010);
    chk("R7 ctrl readback sel", ctrl_rd, 32'h2);
    wr_sp(32'h1000_0203);
    chk("R2 process pointer active", sp_rd, 32'h1000_0200);
    wr_ctrl(3'b000);
    chk("R5 main untouched by process write", sp_rd, 32'h2000_0FF4);
    wr_ctrl(3'b010);
    chk("R2 process pointer kept", sp_rd, 32'h1000_0200);
  endtask

  task automatic t_handler();
    set_mode(1'b1);
    chk("R3 handler shows main", sp_rd, 32'h2000_0FF4);
    chk("R4 sel reads zero in handler", ctrl_rd, 32'h0);
    wr_ctrl(3'b000);
    wr_sp(32'h2000_0E01);
    chk("R3 handler write to main", sp_rd, 32'h2000_0E00);
    set_mode(1'b0);
    chk("R4 sel kept after handler write", ctrl_rd, 32'h2);
    chk("R3 process untouched by handler write", sp_rd, 32'h1000_0200);
  endtask

  task automatic t_unpriv();
    wr_ctrl(3'b011);
    chk("R7 priv drops", {31'b0, priv}, 32'h0);
    chk("R7 ctrl unpriv", ctrl_rd, 32'h3);
    wr_ctrl(3'b100);
    chk("R6 unpriv write dropped", ctrl_rd, 32'h3);
    chk("R6 priv still low", {31'b0, priv}, 32'h0);
    set_mode(1'b1);
    chk("R7 handler privileged", {31'b0, priv}, 32'h1);
    wr_ctrl(3'b000);
    set_mode(1'b0);
    chk("R7 privilege restored", ctrl_rd, 32'h2);
  endtask

  task automatic t_exc_return();
    set_mode(1'b1);
    exc_ret = 1'b1; ret_code = 2'b10;
    step();
    exc_ret = 1'b0;
    set_mode(1'b0);
    chk("R8 return thread main", ctrl_rd, 32'h0);
    chk("R8 main active after return", sp_rd, 32'h2000_0E00);
    set_mode(1'b1);
    exc_ret = 1'b1; ret_code = 2'b11;
    step();
    exc_ret = 1'b0;
    set_mode(1'b0);
    chk("R8 return thread process", ctrl_rd, 32'h2);
    exc_ret = 1'b1; ret_code = 2'b00;
    step();
    exc_ret = 1'b0;
    chk("R8 return to handler keeps sel", ctrl_rd, 32'h2);
    exc_ret = 1'b1; ret_code = 2'b11;
    ctrl_wr_en = 1'b1; ctrl_wr_data = 3'b000;
    step();
    exc_ret = 1'b0; ctrl_wr_en = 1'b0;
    chk("R8 return beats ctrl write", ctrl_rd, 32'h2);
  endtask

  task automatic t_entry_fp();
    wr_ctrl(3'b110);
    chk("R7 fp context set", ctrl_rd, 32'h6);
    chk("R10 no-fp variant reads zero", ctrl_rd_nf, 32'h2);
    exc_entry = 1'b1;
    ctrl_wr_en = 1'b1; ctrl_wr_data = 3'b110;
    step();
    exc_entry = 1'b0; ctrl_wr_en = 1'b0;
    chk("R9 entry clears fp context", ctrl_rd, 32'h2);
  endtask

  initial begin : main
    t_reset();
    t_thread_select();
    t_handler();
    t_unpriv();
    t_exc_return();
    t_entry_fp();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule